// File: doc/BRIEF.md
# CAN Fault Confinement and Error Interrupt Unit

This block keeps the transmit and receive error counters of a CAN node and derives its fault-confinement state from them. The four states are error-active, warning, error-passive and bus-off. A protocol engine reports error and success events as single-cycle pulses. The block turns each pulse into a counter step. It also captures the engine's protocol error reports into a sticky error-status register, which software clears by writing ones.

When the node enters warning, error-passive or bus-off, the block raises a matching interrupt flag. It raises further flags for system and mailbox events reported by neighbouring logic. A global mask enables each flag, enables each of two interrupt lines, and chooses the line that system interrupts use. Mailbox-class interrupts follow their own line select. Bus-off freezes both counters. The node leaves bus-off only after a set number of recovery indications, each standing for one sequence of 11 recessive bits. Both counters then return to zero.

Top module: `can_fault_conf`

## Requirements
- R1: A `tx_err_i` pulse adds 8 to the transmit counter, and a `tx_ok_i` pulse subtracts 1 from it, stopping at 0. If both arrive together, the error wins. An `rx_err_i` pulse adds 1 to the receive counter, saturating at 255, and an `rx_ok_i` pulse subtracts 1, stopping at 0. Counter values appear one clock after the pulse.
- R2: `state_o` is 0 (active) while both counters are below 96. It is 1 (warning) when either counter is at least 96 and both are below 128. It is 2 (passive) when either counter is at least 128. It changes in the same clock as the counter.
- R3: When the transmit counter would exceed 255, `state_o` becomes 3 (bus-off). While in bus-off, both counters hold their values and ignore all increment and decrement pulses.
- R4: In bus-off, the 128th `recess_i` pulse returns both counters to 0 and `state_o` to 0. Pulses outside bus-off have no effect.
- R5: A pulse on `prot_err_i[i]` sets error-status bit 19+i. The bits are: ack 19, stuff 20, CRC 21, stuck-dominant 22, bit 23, form 24. A set bit stays set until a 1 is written to it through `es_clr_i`. A set arriving in the same clock as a clear wins.
- R6: Entering warning, passive or bus-off sets interrupt flag 8, 9 or 10 respectively, and error-status bit 16, 17 or 18, one clock after `state_o` changes. The set happens only on entry, never again while the node stays in that state.
- R7: A pulse on `sys_evt_i[i]` sets flag 11+i. The flags are: message lost 11, wake-up 12, write denied 13, abort ack 14, global mailbox 15, timer overflow 16, message alarm 17. A global-mailbox pulse also loads `mbox_num_i` into flag bits 4:0.
- R8: Flag bits 31:5 are cleared by writing 1s through `gif_clr_i`. A set in the same clock wins. Bits 4:0 are not affected by the clear.
- R9: One clock after a flag is set, each line is recomputed. A line is high when its enable is set (`gim_i` bit 0 for line 0, bit 1 for line 1) and a flag routed to it has its mask bit `gim_i[n]` set. Flags 8-14 and 16 go to line 1 when `gim_i[2]` is 1, otherwise to line 0. Flags 15 and 17 go to line 1 when `mbox_l1_i` is 1, otherwise to line 0.
- R10: Reset clears the counters, the state, both registers and both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_err_i | input | 1 | Transmit error pulse |
| tx_ok_i | input | 1 | Transmit success pulse |
| rx_err_i | input | 1 | Receive error pulse |
| rx_ok_i | input | 1 | Receive success pulse |
| recess_i | input | 1 | One 11-recessive-bit sequence seen |
| prot_err_i | input | 6 | Protocol error reports, bit i to status bit 19+i |
| sys_evt_i | input | 7 | System/mailbox event pulses, bit i to flag 11+i |
| mbox_num_i | input | 5 | Mailbox number for a global mailbox event |
| es_clr_i | input | 32 | Write-1-to-clear strobe for error status |
| gif_clr_i | input | 32 | Write-1-to-clear strobe for interrupt flags |
| gim_i | input | 32 | Global mask: line enables, system line select, flag enables |
| mbox_l1_i | input | 1 | Route mailbox-class flags to line 1 |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |
| state_o | output | 2 | Fault-confinement state |
| es_o | output | 32 | Error-status register |
| gif_o | output | 32 | Interrupt flag register |
| irq0_o | output | 1 | Interrupt line 0 |
| irq1_o | output | 1 | Interrupt line 1 |

## Verification
Results fall due at three different latencies. Counters, state, protocol status bits and event flags are due one clock after their pulse. The entry flags and status bits 16-18 are due two clocks after a counter pulse. The interrupt lines are due one clock after the flag or mask that drives them. The bench drives inputs at the falling edge and samples at later falling edges. Before each sample it waits exactly the number of rising edges that the result's latency requires. At the threshold boundaries it checks both the cycle just below the threshold and the cycle that crosses it.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_WARN   = 2'd1,
    ST_PASS   = 2'd2,
    ST_BOFF   = 2'd3
  } fc_state_e;

  localparam int ES_WARN    = 16;
  localparam int ES_PASS    = 17;
  localparam int ES_BOFF    = 18;
  localparam int ES_PROT_LO = 19;
  localparam int NPROT      = 6;

  localparam int GF_WARN   = 8;
  localparam int GF_PASS   = 9;
  localparam int GF_BOFF   = 10;
  localparam int GF_EVT_LO = 11;
  localparam int NEVT      = 7;
  localparam int GF_GMBX   = 15;
  localparam int MBX_W     = 5;

  localparam int GM_L0EN   = 0;
  localparam int GM_L1EN   = 1;
  localparam int GM_SYS_L1 = 2;

  localparam logic [REG_W-1:0] ES_USED   = 32'h01FF_0000;
  localparam logic [REG_W-1:0] GF_USED   = 32'h0003_FF00;
  localparam logic [REG_W-1:0] GF_SYS    = 32'h0001_7F00;
  localparam logic [REG_W-1:0] GF_MBXCLS = 32'h0002_8000;
endpackage

// File: rtl/can_fc_counters.sv
module can_fc_counters
  import can_fc_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int TX_STEP  = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 255,
  parameter int RECOV_N  = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_ok_i,
  input  logic             recess_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output fc_state_e        state_o
);
  localparam int RC_W = $clog2(RECOV_N + 1);

  logic [CNT_W-1:0] tec_q, tec_n, rec_q, rec_n;
  logic [RC_W-1:0]  rc_q, rc_n;
  logic             boff_q, boff_n;
  fc_state_e        state_q, state_n;

  always_comb begin
    tec_n  = tec_q;
    rec_n  = rec_q;
    rc_n   = rc_q;
    boff_n = boff_q;
    if (boff_q) begin
      if (recess_i) begin
        if (rc_q == RC_W'(RECOV_N - 1)) begin
          tec_n  = '0;
          rec_n  = '0;
          rc_n   = '0;
          boff_n = 1'b0;
        end else begin
          rc_n = rc_q + 1'b1;
        end
      end
    end else begin
      if (tx_err_i)
        tec_n = tec_q + CNT_W'(TX_STEP);
      else if (tx_ok_i && tec_q != '0)
        tec_n = tec_q - 1'b1;
      if (rx_err_i && rec_q < CNT_W'(BOFF_LIM))
        rec_n = rec_q + 1'b1;
      else if (rx_ok_i && rec_q != '0)
        rec_n = rec_q - 1'b1;
      if (tec_n > CNT_W'(BOFF_LIM))
        boff_n = 1'b1;
    end
  end

  always_comb begin
    if (boff_n)
      state_n = ST_BOFF;
    else if (tec_n >= CNT_W'(PASS_LIM) || rec_n >= CNT_W'(PASS_LIM))
      state_n = ST_PASS;
    else if (tec_n >= CNT_W'(WARN_LIM) || rec_n >= CNT_W'(WARN_LIM))
      state_n = ST_WARN;
    else
      state_n = ST_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tec_q   <= '0;
      rec_q   <= '0;
      rc_q    <= '0;
      boff_q  <= 1'b0;
      state_q <= ST_ACTIVE;
    end else begin
      tec_q   <= tec_n;
      rec_q   <= rec_n;
      rc_q    <= rc_n;
      boff_q  <= boff_n;
      state_q <= state_n;
    end
  end

  assign tec_o   = tec_q;
  assign rec_o   = rec_q;
  assign state_o = state_q;

  AST_REC_CAPPED: assert property (@(posedge clk) disable iff (rst) rec_q <= CNT_W'(BOFF_LIM)); // R1
  AST_BOFF_ENTRY: assert property (@(posedge clk) disable iff (rst) $rose(boff_q) |-> tec_q > CNT_W'(BOFF_LIM)); // R3
  AST_BOFF_FROZEN: assert property (@(posedge clk) disable iff (rst) (boff_q && !recess_i) |=> ($stable(tec_q) && $stable(rec_q))); // R3
  AST_RECOV_ZERO: assert property (@(posedge clk) disable iff (rst) $fell(boff_q) |-> (tec_q == '0 && rec_q == '0)); // R4
endmodule

// File: rtl/can_fc_flags.sv
module can_fc_flags
  import can_fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  fc_state_e        state_i,
  input  logic [NPROT-1:0] prot_err_i,
  input  logic [NEVT-1:0]  sys_evt_i,
  input  logic [MBX_W-1:0] mbox_num_i,
  input  logic [REG_W-1:0] es_clr_i,
  input  logic [REG_W-1:0] gif_clr_i,
  output logic [REG_W-1:0] es_o,
  output logic [REG_W-1:0] gif_o
);
  logic             warn_lv, pass_lv, boff_lv;
  logic             warn_pq, pass_pq, boff_pq;
  logic [REG_W-1:0] es_set, gif_set, es_q, gif_q;

  assign warn_lv = (state_i != ST_ACTIVE);
  assign pass_lv = (state_i == ST_PASS) || (state_i == ST_BOFF);
  assign boff_lv = (state_i == ST_BOFF);

  always_comb begin
    es_set  = '0;
    gif_set = '0;
    for (int i = 0; i < NPROT; i++)
      es_set[ES_PROT_LO + i] = prot_err_i[i];
    for (int i = 0; i < NEVT; i++)
      gif_set[GF_EVT_LO + i] = sys_evt_i[i];
    es_set[ES_WARN]  = warn_lv & ~warn_pq;
    es_set[ES_PASS]  = pass_lv & ~pass_pq;
    es_set[ES_BOFF]  = boff_lv & ~boff_pq;
    gif_set[GF_WARN] = warn_lv & ~warn_pq;
    gif_set[GF_PASS] = pass_lv & ~pass_pq;
    gif_set[GF_BOFF] = boff_lv & ~boff_pq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_pq <= 1'b0;
      pass_pq <= 1'b0;
      boff_pq <= 1'b0;
      es_q    <= '0;
      gif_q   <= '0;
    end else begin
      warn_pq <= warn_lv;
      pass_pq <= pass_lv;
      boff_pq <= boff_lv;
      es_q    <= ((es_q & ~es_clr_i) | es_set) & ES_USED;
      gif_q[REG_W-1:MBX_W] <= ((gif_q[REG_W-1:MBX_W] & ~gif_clr_i[REG_W-1:MBX_W])
                              | gif_set[REG_W-1:MBX_W]) & GF_USED[REG_W-1:MBX_W];
      if (sys_evt_i[GF_GMBX - GF_EVT_LO])
        gif_q[MBX_W-1:0] <= mbox_num_i;
    end
  end

  assign es_o  = es_q;
  assign gif_o = gif_q;

  AST_BOFF_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (rst) $rose(gif_q[GF_BOFF]) |-> state_i == ST_BOFF); // R6
  AST_PASS_FLAG_ON_ENTRY: assert property (@(posedge clk) disable iff (rst) $rose(gif_q[GF_PASS]) |-> pass_lv); // R6
  AST_FORM_STICKY: assert property (@(posedge clk) disable iff (rst) (es_q[ES_PROT_LO + 5] && !es_clr_i[ES_PROT_LO + 5]) |=> es_q[ES_PROT_LO + 5]); // R5
endmodule

// File: rtl/can_fc_router.sv
module can_fc_router
  import can_fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] gif_i,
  input  logic [REG_W-1:0] gim_i,
  input  logic             mbox_l1_i,
  output logic             irq0_o,
  output logic             irq1_o
);
  logic [REG_W-1:0] act, to_l1, to_l0;
  logic             irq0_q, irq1_q;

  always_comb begin
    act   = gif_i & gim_i & GF_USED;
    to_l1 = (act & GF_SYS & {REG_W{gim_i[GM_SYS_L1]}})
          | (act & GF_MBXCLS & {REG_W{mbox_l1_i}});
    to_l0 = act & ~to_l1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0_q <= 1'b0;
      irq1_q <= 1'b0;
    end else begin
      irq0_q <= gim_i[GM_L0EN] & (|to_l0);
      irq1_q <= gim_i[GM_L1EN] & (|to_l1);
    end
  end

  assign irq0_o = irq0_q;
  assign irq1_o = irq1_q;

  AST_L0_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) irq0_q |-> $past(gim_i[GM_L0EN])); // R9
  AST_L1_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) irq1_q |-> $past(gim_i[GM_L1EN])); // R9
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst) (irq0_q || irq1_q) |-> $past(|(gif_i & GF_USED))); // R9
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int TX_STEP  = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 255,
  parameter int RECOV_N  = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_ok_i,
  input  logic             recess_i,
  input  logic [5:0]       prot_err_i,
  input  logic [6:0]       sys_evt_i,
  input  logic [4:0]       mbox_num_i,
  input  logic [31:0]      es_clr_i,
  input  logic [31:0]      gif_clr_i,
  input  logic [31:0]      gim_i,
  input  logic             mbox_l1_i,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic [1:0]       state_o,
  output logic [31:0]      es_o,
  output logic [31:0]      gif_o,
  output logic             irq0_o,
  output logic             irq1_o
);
  fc_state_e        st;
  logic [REG_W-1:0] gif_w;

  can_fc_counters #(
    .CNT_W(CNT_W), .TX_STEP(TX_STEP), .WARN_LIM(WARN_LIM),
    .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM), .RECOV_N(RECOV_N)
  ) u_cnt (
    .clk(clk), .rst(rst),
    .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i),
    .rx_err_i(rx_err_i), .rx_ok_i(rx_ok_i),
    .recess_i(recess_i),
    .tec_o(tec_o), .rec_o(rec_o), .state_o(st)
  );

  can_fc_flags u_flg (
    .clk(clk), .rst(rst), .state_i(st),
    .prot_err_i(prot_err_i), .sys_evt_i(sys_evt_i), .mbox_num_i(mbox_num_i),
    .es_clr_i(es_clr_i), .gif_clr_i(gif_clr_i),
    .es_o(es_o), .gif_o(gif_w)
  );

  can_fc_router u_rte (
    .clk(clk), .rst(rst), .gif_i(gif_w), .gim_i(gim_i),
    .mbox_l1_i(mbox_l1_i), .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  assign gif_o   = gif_w;
  assign state_o = st;
endmodule

// File: tb/sim_can_fault_conf.sv
module sim_can_fault_conf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_err_i = 0, tx_ok_i = 0, rx_err_i = 0, rx_ok_i = 0, recess_i = 0;
  logic [5:0]  prot_err_i = '0;
  logic [6:0]  sys_evt_i = '0;
  logic [4:0]  mbox_num_i = '0;
  logic [31:0] es_clr_i = '0, gif_clr_i = '0, gim_i = '0;
  logic        mbox_l1_i = 1'b0;
  logic [8:0]  tec_o, rec_o;
  logic [1:0]  state_o;
  logic [31:0] es_o, gif_o;
  logic        irq0_o, irq1_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_conf u0 (
    .clk(clk), .rst(rst),
    .tx_err_i(tx_err_i), .tx_ok_i(tx_ok_i), .rx_err_i(rx_err_i), .rx_ok_i(rx_ok_i),
    .recess_i(recess_i), .prot_err_i(prot_err_i), .sys_evt_i(sys_evt_i),
    .mbox_num_i(mbox_num_i), .es_clr_i(es_clr_i), .gif_clr_i(gif_clr_i),
    .gim_i(gim_i), .mbox_l1_i(mbox_l1_i),
    .tec_o(tec_o), .rec_o(rec_o), .state_o(state_o), .es_o(es_o), .gif_o(gif_o),
    .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  typedef struct packed {
    logic       te, to, re, ro;
    logic [8:0] tec;
    logic [8:0] rec;
    logic [1:0] st;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 9'd8,  9'd0, 2'd0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd7,  9'd0, 2'd0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 9'd7,  9'd1, 2'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 9'd7,  9'd0, 2'd0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 9'd7,  9'd0, 2'd0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 9'd15, 9'd1, 2'd0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 9'd23, 9'd1, 2'd0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 9'd22, 9'd1, 2'd0}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_errs(int n);
    tx_err_i = 1'b1; repeat (n) @(negedge clk); tx_err_i = 1'b0;
  endtask
  task automatic rx_errs(int n);
    rx_err_i = 1'b1; repeat (n) @(negedge clk); rx_err_i = 1'b0;
  endtask
  task automatic recess(int n);
    recess_i = 1'b1; repeat (n) @(negedge clk); recess_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R10 tec after reset", 32'(tec_o), 0);
    check("R10 rec after reset", 32'(rec_o), 0);
    check("R10 state after reset", 32'(state_o), 0);
    check("R10 es after reset", es_o, 0);
    check("R10 gif after reset", gif_o, 0);
    check("R10 lines after reset", {30'd0, irq1_o, irq0_o}, 0);

    // R1 table walk
    for (int i = 0; i < NV; i++) begin
      tx_err_i = VECS[i].te; tx_ok_i = VECS[i].to;
      rx_err_i = VECS[i].re; rx_ok_i = VECS[i].ro;
      @(negedge clk);
      check($sformatf("R1 tec vec%0d", i), 32'(tec_o), 32'(VECS[i].tec));
      check($sformatf("R1 rec vec%0d", i), 32'(rec_o), 32'(VECS[i].rec));
      check($sformatf("R2 state vec%0d", i), 32'(state_o), 32'(VECS[i].st));
    end
    tx_err_i = 0; tx_ok_i = 0; rx_err_i = 0; rx_ok_i = 0;

    rst = 1'b1; @(negedge clk); rst = 1'b0;
    gim_i = 32'h0000_0701;

    rx_errs(95);
    check("R2 rec 95", 32'(rec_o), 95);
    check("R2 below warn", 32'(state_o), 0);
    rx_errs(1);
    check("R2 warn at 96", 32'(state_o), 1);
    check("R6 warn flag not yet", 32'(gif_o[8]), 0);
    @(negedge clk);
    check("R6 warn flag", 32'(gif_o[8]), 1);
    check("R6 warn status", 32'(es_o[16]), 1);
    @(negedge clk);
    check("R9 line0 warn", 32'(irq0_o), 1);
    gif_clr_i = 32'h0000_0100; @(negedge clk); gif_clr_i = '0;
    check("R8 warn flag cleared", 32'(gif_o[8]), 0);
    rx_errs(1);
    @(negedge clk);
    check("R6 no refire in warn", 32'(gif_o[8]), 0);
    check("R9 line0 low after clear", 32'(irq0_o), 0);

    rx_errs(30);
    check("R2 rec 127 still warn", 32'(state_o), 1);
    rx_errs(1);
    check("R2 passive at 128", 32'(state_o), 2);
    @(negedge clk);
    check("R6 passive flag", 32'(gif_o[9]), 1);
    check("R6 passive status", 32'(es_o[17]), 1);
    @(negedge clk);
    check("R9 line0 passive", 32'(irq0_o), 1);
    gim_i = 32'h0000_0707;
    @(negedge clk);
    check("R9 system to line1", 32'(irq1_o), 1);
    check("R9 line0 off when steered", 32'(irq0_o), 0);

    tx_errs(31);
    check("R3 tec 248", 32'(tec_o), 248);
    check("R3 not yet bus-off", 32'(state_o), 2);
    tx_errs(1);
    check("R3 bus-off", 32'(state_o), 3);
    check("R3 tec 256", 32'(tec_o), 256);
    @(negedge clk);
    check("R6 bus-off flag", 32'(gif_o[10]), 1);
    check("R6 bus-off status", 32'(es_o[18]), 1);
    tx_ok_i = 1; rx_ok_i = 1; tx_err_i = 1; rx_err_i = 1;
    @(negedge clk);
    tx_ok_i = 0; rx_ok_i = 0; tx_err_i = 0; rx_err_i = 0;
    check("R3 tec frozen", 32'(tec_o), 256);
    check("R3 rec frozen", 32'(rec_o), 128);

    recess(127);
    check("R4 still bus-off at 127", 32'(state_o), 3);
    recess(1);
    check("R4 tec cleared", 32'(tec_o), 0);
    check("R4 rec cleared", 32'(rec_o), 0);
    check("R4 active", 32'(state_o), 0);
    recess(5);
    tx_errs(1);
    check("R4 recess ignored outside bus-off", 32'(tec_o), 8);

    prot_err_i = 6'b100001; @(negedge clk); prot_err_i = '0;
    check("R5 form bit", 32'(es_o[24]), 1);
    check("R5 ack bit", 32'(es_o[19]), 1);
    es_clr_i = 32'h0108_0000; prot_err_i = 6'b100000;
    @(negedge clk);
    es_clr_i = '0; prot_err_i = '0;
    check("R5 set wins over clear", 32'(es_o[24]), 1);
    check("R5 ack cleared", 32'(es_o[19]), 0);
    es_clr_i = 32'h0100_0000; @(negedge clk); es_clr_i = '0;
    check("R5 form cleared", 32'(es_o[24]), 0);

    gim_i = 32'h0000_8001; mbox_l1_i = 0;
    sys_evt_i = 7'b0010000; mbox_num_i = 5'd19;
    @(negedge clk);
    sys_evt_i = '0; mbox_num_i = '0;
    check("R7 mailbox flag", 32'(gif_o[15]), 1);
    check("R7 mailbox number", 32'(gif_o[4:0]), 19);
    @(negedge clk);
    check("R9 mailbox on line0", {30'd0, irq1_o, irq0_o}, 1);
    gim_i = 32'h0000_8003; mbox_l1_i = 1;
    @(negedge clk);
    check("R9 mailbox on line1", {30'd0, irq1_o, irq0_o}, 2);
    sys_evt_i = 7'b0000001; @(negedge clk); sys_evt_i = '0;
    check("R7 message lost flag", 32'(gif_o[11]), 1);
    gif_clr_i = 32'hFFFF_FFE0; @(negedge clk); gif_clr_i = '0;
    check("R8 flags cleared", {5'd0, gif_o[31:5]}, 0);
    check("R8 number kept", 32'(gif_o[4:0]), 19);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule